// File: doc/BRIEF.md
# Thermal Throttling Trigger Controller

This block decides when a chip should slow itself down because it is running hot, and when it may return to full speed. Several on-chip temperature sensors each present an unsigned reading every clock cycle. The controller takes the hottest reading and averages it over a long, fixed window of cycles. Brief spikes therefore do not provoke a reaction. Only a finished window average is compared against a programmable trigger level.

When the average reaches the trigger level, the controller waits a programmable initiation delay. It then raises a request for a lower voltage and frequency point. It stays in that phase until the scaling controller reports that the new point is in effect. The response is then held for a programmed number of cycles. After the hold, the next window average is compared with a release threshold set below the trigger level, which gives hysteresis. If the average is still at or above the release threshold, the hold starts again. Otherwise the request is dropped, and the controller waits for the scaling controller to confirm that the normal point is restored before it resumes monitoring.

Top module: `thermal_throttle_ctrl`

## Requirements
- R1: After a synchronous active-high reset, `state_o` reads 0 (idle) and `scale_down_o` is 0.
- R2: The value that is averaged is, each cycle, the maximum of all `NSENS` sensor readings, so one hot sensor is enough to trigger.
- R3: Readings are block-averaged over 2^`WIN_LOG2` consecutive cycles (default 2^17 = 131072 cycles). Comparisons are made only when a window completes, so a one-cycle spike whose window average stays below the trigger level never leaves idle.
- R4: In idle, a completed window average greater than or equal to `trig_lvl_i` moves the state to initiating (code 1). A lower average keeps the state idle.
- R5: The initiating state lasts exactly `init_dly_i`+1 cycles. The state then becomes engaging (code 2), where `scale_down_o` is 1.
- R6: The engaging state persists, with `scale_down_o` at 1, until `scale_done_i` is sampled high. The state then becomes policy-hold (code 3).
- R7: Policy-hold lasts exactly `policy_cyc_i`+1 cycles. The state then becomes recheck (code 4). `scale_down_o` stays 1 in both states.
- R8: In recheck, the next completed window average is compared with `rel_lvl_i`. If it is greater than or equal to `rel_lvl_i`, the state returns to policy-hold with the full duration. If it is below `rel_lvl_i`, the state goes to shutting-off (code 5).
- R9: In shutting-off, `scale_down_o` is 0, and the state persists until `scale_done_i` is sampled high. It then returns to idle, and monitoring resumes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| temp_i | input | NSENS*TW | Sensor readings; sensor k occupies bits [k*TW +: TW] |
| trig_lvl_i | input | TW | Trigger level for the window average |
| rel_lvl_i | input | TW | Release threshold used at recheck |
| init_dly_i | input | CW | Initiation delay count |
| policy_cyc_i | input | CW | Policy hold count |
| scale_done_i | input | 1 | Scaling controller reports the requested point reached |
| scale_down_o | output | 1 | Request for the reduced operating point |
| state_o | output | 3 | Phase: 0 idle, 1 initiating, 2 engaging, 3 policy-hold, 4 recheck, 5 shutting-off |

## Verification
On every cycle, the assertions check the following behaviours. Idle is left only on a completed window at or above the trigger. The engaging and shutting-off phases wait for the scaling controller's completion. A recheck at or above the release threshold always returns to hold. The averaged value is never below any sensor reading. Window-completion pulses are isolated single cycles. The bench scenarios cover what needs known stimulus: hottest-sensor selection across sensor patterns, equality at the trigger and release levels, the rejection of a short spike, and the exact lengths of the initiation and hold phases.

// File: rtl/thr_pkg.sv
package thr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_INIT   = 3'd1,
        ST_ENGAGE = 3'd2,
        ST_HOLD   = 3'd3,
        ST_CHECK  = 3'd4,
        ST_SHUT   = 3'd5
    } thr_st_t;

    function automatic logic req_active(thr_st_t s);
        return (s == ST_ENGAGE) || (s == ST_HOLD) || (s == ST_CHECK);
    endfunction

endpackage

// File: rtl/thr_hot_sel.sv
module thr_hot_sel #(
    parameter int NSENS = 3,
    parameter int TW    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NSENS*TW-1:0] temp_i,
    output logic [TW-1:0]       hot_o
);
    logic [TW-1:0] max_c;

    always_comb begin
        max_c = '0;
        for (int i = 0; i < NSENS; i++) begin
            if (temp_i[i*TW +: TW] > max_c) max_c = temp_i[i*TW +: TW];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) hot_o <= '0;
        else     hot_o <= max_c;
    end

    for (genvar g = 0; g < NSENS; g++) begin : g_chk
        // R2
        hot_ge_sensor_chk: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> hot_o >= $past(temp_i[g*TW +: TW]));
    end

endmodule

// File: rtl/thr_win_avg.sv
module thr_win_avg #(
    parameter int TW       = 8,
    parameter int WIN_LOG2 = 17
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] val_i,
    output logic [TW-1:0] avg_o,
    output logic          avg_vld_o
);
    localparam int AW = TW + WIN_LOG2;

    logic [WIN_LOG2-1:0] pos_q;
    logic [AW-1:0]       acc_q;
    logic [AW-1:0]       sum_c;

    assign sum_c = acc_q + AW'(val_i);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q     <= '0;
            acc_q     <= '0;
            avg_o     <= '0;
            avg_vld_o <= 1'b0;
        end else begin
            pos_q <= pos_q + 1'b1;
            if (&pos_q) begin
                acc_q     <= '0;
                avg_o     <= sum_c[AW-1:WIN_LOG2];
                avg_vld_o <= 1'b1;
            end else begin
                acc_q     <= sum_c;
                avg_vld_o <= 1'b0;
            end
        end
    end

    // R3
    win_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        avg_vld_o |=> !avg_vld_o);

endmodule

// File: rtl/thr_seq.sv
module thr_seq
    import thr_pkg::*;
#(
    parameter int TW = 8,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [TW-1:0] avg_i,
    input  logic          avg_vld_i,
    input  logic [TW-1:0] trig_lvl_i,
    input  logic [TW-1:0] rel_lvl_i,
    input  logic [CW-1:0] init_dly_i,
    input  logic [CW-1:0] policy_cyc_i,
    input  logic          scale_done_i,
    output thr_st_t       st_o
);
    thr_st_t       st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        case (st_q)
            ST_IDLE: if (avg_vld_i && avg_i >= trig_lvl_i) begin
                st_d  = ST_INIT;
                cnt_d = init_dly_i;
            end
            ST_INIT: begin
                if (cnt_q == '0) st_d = ST_ENGAGE;
                else             cnt_d = cnt_q - 1'b1;
            end
            ST_ENGAGE: if (scale_done_i) begin
                st_d  = ST_HOLD;
                cnt_d = policy_cyc_i;
            end
            ST_HOLD: begin
                if (cnt_q == '0) st_d = ST_CHECK;
                else             cnt_d = cnt_q - 1'b1;
            end
            ST_CHECK: if (avg_vld_i) begin
                if (avg_i < rel_lvl_i) begin
                    st_d = ST_SHUT;
                end else begin
                    st_d  = ST_HOLD;
                    cnt_d = policy_cyc_i;
                end
            end
            ST_SHUT: if (scale_done_i) st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cnt_q <= '0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
        end
    end

    assign st_o = st_q;

    // R4
    idle_stay_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_IDLE && !(avg_vld_i && avg_i >= trig_lvl_i)) |=> st_q == ST_IDLE);
    // R6
    engage_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_ENGAGE && !scale_done_i) |=> st_q == ST_ENGAGE);
    // R8
    recheck_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_CHECK && avg_vld_i && avg_i >= rel_lvl_i) |=> st_q == ST_HOLD);
    // R9
    shut_wait_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q == ST_SHUT && !scale_done_i) |=> st_q == ST_SHUT);

endmodule

// File: rtl/thermal_throttle_ctrl.sv
module thermal_throttle_ctrl
    import thr_pkg::*;
#(
    parameter int NSENS    = 3,
    parameter int TW       = 8,
    parameter int WIN_LOG2 = 17,
    parameter int CW       = 24
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NSENS*TW-1:0] temp_i,
    input  logic [TW-1:0]       trig_lvl_i,
    input  logic [TW-1:0]       rel_lvl_i,
    input  logic [CW-1:0]       init_dly_i,
    input  logic [CW-1:0]       policy_cyc_i,
    input  logic                scale_done_i,
    output logic                scale_down_o,
    output logic [2:0]          state_o
);
    logic [TW-1:0] hot;
    logic [TW-1:0] avg;
    logic          avg_vld;
    thr_st_t       st;

    thr_hot_sel #(.NSENS(NSENS), .TW(TW)) i_hot (
        .clk(clk), .rst(rst), .temp_i(temp_i), .hot_o(hot)
    );

    thr_win_avg #(.TW(TW), .WIN_LOG2(WIN_LOG2)) i_avg (
        .clk(clk), .rst(rst), .val_i(hot), .avg_o(avg), .avg_vld_o(avg_vld)
    );

    thr_seq #(.TW(TW), .CW(CW)) i_seq (
        .clk(clk), .rst(rst), .avg_i(avg), .avg_vld_i(avg_vld),
        .trig_lvl_i(trig_lvl_i), .rel_lvl_i(rel_lvl_i),
        .init_dly_i(init_dly_i), .policy_cyc_i(policy_cyc_i),
        .scale_done_i(scale_done_i), .st_o(st)
    );

    assign scale_down_o = req_active(st);
    assign state_o      = st;

    // R5
    req_after_init_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_INIT && $past(st) == ST_INIT && !rst) |-> !scale_down_o);

endmodule

// File: tb/test_thermal_throttle_ctrl.sv
module test_thermal_throttle_ctrl;
    localparam int NSENS = 3;
    localparam int TW    = 8;
    localparam int WL    = 4;
    localparam int CW    = 24;
    localparam int WIN   = 1 << WL;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NSENS*TW-1:0] temp = '0;
    logic [TW-1:0]       trig = 8'd60;
    logic [TW-1:0]       rel  = 8'd50;
    logic [CW-1:0]       idly = 24'd1000;
    logic [CW-1:0]       pol  = 24'd20;
    logic                done = 1'b0;
    logic                sdown;
    logic [2:0]          st;

    int n_chk  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    thermal_throttle_ctrl #(.NSENS(NSENS), .TW(TW), .WIN_LOG2(WL), .CW(CW))
    i_thermal_throttle_ctrl (
        .clk(clk), .rst(rst), .temp_i(temp), .trig_lvl_i(trig), .rel_lvl_i(rel),
        .init_dly_i(idly), .policy_cyc_i(pol), .scale_done_i(done),
        .scale_down_o(sdown), .state_o(st)
    );

    // {t0, t1, t2, trigger, expected state}
    localparam logic [39:0] VEC [7] = '{
        {8'd70,  8'd20,  8'd20,  8'd60,  8'd1},
        {8'd20,  8'd20,  8'd61,  8'd60,  8'd1},
        {8'd60,  8'd10,  8'd10,  8'd60,  8'd1},
        {8'd59,  8'd59,  8'd59,  8'd60,  8'd0},
        {8'd10,  8'd59,  8'd30,  8'd60,  8'd0},
        {8'd0,   8'd0,   8'd255, 8'd255, 8'd1},
        {8'd100, 8'd100, 8'd100, 8'd200, 8'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic set_all(input logic [TW-1:0] v);
        temp = {v, v, v};
    endtask

    task automatic wait_st(input int code, input int lim);
        for (int i = 0; i < lim; i++) begin
            if (st == 3'(code)) break;
            @(negedge clk);
        end
    endtask

    task automatic wait_leave(input int code, input int lim);
        for (int i = 0; i < lim; i++) begin
            if (st != 3'(code)) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse_done();
        done = 1'b1;
        @(negedge clk);
        done = 1'b0;
    endtask

    function automatic int stay_len(input int code);
        return 0;
    endfunction

    task automatic measure(input int code, output int n);
        n = 0;
        while (st == 3'(code) && n < 100000) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n;
        @(negedge clk);
        do_reset();
        // R1
        chk("R1 state", int'(st), 0);
        chk("R1 scale_down", int'(sdown), 0);

        // R2 R4: table of sensor patterns
        foreach (VEC[k]) begin
            temp = VEC[k][39:16];
            trig = VEC[k][15:8];
            idly = 24'd1000;
            do_reset();
            repeat (4 * WIN) @(negedge clk);
            chk($sformatf("R2/R4 vector %0d", k), int'(st), int'(VEC[k][7:0]));
        end

        // R3: one-cycle spike, window average stays below trigger
        trig = 8'd60;
        set_all(8'd40);
        do_reset();
        repeat (WIN + 5) @(negedge clk);
        temp[15:8] = 8'd255;
        @(negedge clk);
        set_all(8'd40);
        repeat (3 * WIN) @(negedge clk);
        chk("R3 spike ignored", int'(st), 0);

        // Full engage / hold / recheck / release sequence
        trig = 8'd60;
        rel  = 8'd50;
        idly = 24'd5;
        pol  = 24'd20;
        set_all(8'd70);
        do_reset();
        wait_st(1, 200);
        measure(1, n);
        chk("R5 init length", n, 6);
        chk("R5 engaging state", int'(st), 2);
        chk("R5 scale_down", int'(sdown), 1);
        repeat (10) @(negedge clk);
        chk("R6 waits for done", int'(st), 2);
        pulse_done();
        measure(3, n);
        chk("R7 hold length", n, 21);
        chk("R7 recheck state", int'(st), 4);
        chk("R7 scale_down in recheck", int'(sdown), 1);
        wait_leave(4, 100);
        chk("R8 re-engage when hot", int'(st), 3);
        set_all(8'd50);
        wait_st(4, 100);
        wait_leave(4, 100);
        chk("R8 equal to release keeps hold", int'(st), 3);
        set_all(8'd49);
        wait_st(4, 100);
        wait_leave(4, 100);
        chk("R8 below release shuts off", int'(st), 5);
        chk("R9 scale_down dropped", int'(sdown), 0);
        repeat (5) @(negedge clk);
        chk("R9 waits for done", int'(st), 5);
        pulse_done();
        chk("R9 back to idle", int'(st), 0);
        repeat (4 * WIN) @(negedge clk);
        chk("R9 monitoring resumes idle", int'(st), 0);
        n = stay_len(0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule